// File: doc/BRIEF.md
# Serial Programming Target Port

This block is the device-side end of a four-wire serial programming link. It is active only while an active-low port-select input is held low. It watches the programmer's serial clock and data-in pins with its own fast system clock, so the serial clock never clocks a flop. The incoming bits form fixed 32-bit instructions. Once an unlock instruction has completed, erase, write and read instructions become one-cycle requests on a parallel port to the memory arrays. Read data is shifted back to the programmer in the last byte of the read instruction.

The programmer first sends the unlock instruction. It then reads back the unlock pattern, which the port shifts out during the third byte. If the pattern does not return, the two sides disagree about where instructions start. The programmer can then release and reassert the port select, which restarts the framing.

Top module: `sprog_port`

## Requirements
- R1: While `rst` is high, or for as long as the synchronized `prog_rst_n` is high, `miso` is 0, `mem_req` is 0 and the unlock state is cleared. A partial instruction in progress when `prog_rst_n` rises is discarded, and framing starts from bit 0 when the port is next selected.
- R2: A `mosi` bit is taken in on each rising `sck` edge, most significant bit first. `miso` changes only after a falling `sck` edge and holds steady while `sck` is high.
- R3: Instruction boundaries come from a count of rising `sck` edges, modulo 32. One stray `sck` pulse moves the framing by one bit, so an unlock or a command sent after it is not recognized and issues no request.
- R4: In an instruction whose first byte is 0xAC, the second byte is shifted back out on `miso` while the third byte is shifted in. In any other byte slot `miso` carries zeros, except for the data byte of a read.
- R5: The port unlocks when a completed instruction has first byte 0xAC and second byte 0x53, whatever the third and fourth bytes are.
- R6: Before the port unlocks, no instruction produces a `mem_req`.
- R7: Once unlocked, the instruction 0xAC,0x80,x,x issues a single erase-all request (`mem_cmd` 0, address 0, `mem_hi` 0) after its 32nd bit.
- R8: Once unlocked, the instruction 0x40|H<<3, A_hi, A_lo, D issues a program write (`mem_cmd` 1) after its 32nd bit. The request carries address {A_hi,A_lo}, cut to the program address width, with `mem_hi` = H and `mem_wdata` = D.
- R9: Once unlocked, the instruction 0xC0, A_hi, A_lo, D issues exactly one data write request (`mem_cmd` 2), with no erase request before it. The address is {A_hi,A_lo} cut to the data address width and zero-extended, and `mem_wdata` = D.
- R10: Once unlocked, a program read (0x20|H<<3, mem_cmd 3) or a data read (0xA0, mem_cmd 4) issues its request after the 24th bit. It applies the same address rules as the matching write and sets `mem_wdata` to 0. The byte on `mem_rdata` one cycle after the request is shifted out on `miso` during the fourth byte, most significant bit first.
- R11: `mem_req` is never high for two cycles in a row.
- R12: With `LARGE_MAP` = 0 the program address is 11 bits and the data address 8 bits. With `LARGE_MAP` = 1 they are 12 and 9 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial pins |
| rst | input | 1 | Synchronous active-high system reset |
| prog_rst_n | input | 1 | Port select, active low |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial data to the programmer |
| mem_req | output | 1 | One-cycle memory request strobe |
| mem_cmd | output | 3 | Request kind: 0 erase all, 1 program write, 2 data write, 3 program read, 4 data read |
| mem_addr | output | PAW | Byte or word address of the request |
| mem_hi | output | 1 | High-byte select for program-array accesses |
| mem_wdata | output | 8 | Write data byte |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |

## Verification
The bench sends a stray `sck` pulse and expects the unlock echo and the following erase to vanish. A counter that ignored framing, or that echoed every byte regardless of alignment, would still echo 0x53 and issue the erase. Port select is released in the middle of an instruction and after unlocking. A design that kept its bit count or its unlock state would then misframe the next unlock, or accept an erase that should be refused. Reads are checked for the fourth-byte data on `miso`, and addresses at 0xFFFF are checked for truncation. Launching the read late, or keeping too many address bits, shows up as a wrong byte or a wrong address.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    MC_ERASE   = 3'd0,
    MC_WR_PROG = 3'd1,
    MC_WR_DATA = 3'd2,
    MC_RD_PROG = 3'd3,
    MC_RD_DATA = 3'd4
  } mem_cmd_e;

  localparam logic [7:0] OP_PREFIX  = 8'hAC;
  localparam logic [7:0] OP_UNLOCK  = 8'h53;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_WR_PROG = 8'h40;
  localparam logic [7:0] OP_RD_PROG = 8'h20;
  localparam logic [7:0] OP_WR_DATA = 8'hC0;
  localparam logic [7:0] OP_RD_DATA = 8'hA0;
  localparam logic [7:0] OP_HI_BIT  = 8'h08;

endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sprog_frame.sv
module sprog_frame
  import sprog_pkg::*;
#(
  parameter int WBITS = WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             sck_s,
  input  logic             mosi_s,
  input  logic             tx_load,
  input  logic [7:0]       tx_byte,
  output logic [WBITS-1:0] rx_nx,
  output logic             word_hit,
  output logic             mid_hit,
  output logic             miso
);

  localparam int CW = $clog2(WBITS);
  localparam logic [CW-1:0] LAST_BIT = CW'(WBITS - 1);
  localparam logic [CW-1:0] MID_BIT  = CW'(WBITS - BYTE_W - 1);
  localparam logic [CW-1:0] ECHO_BIT = CW'(2 * BYTE_W - 1);

  logic             sck_q;
  logic [WBITS-1:0] rx_q;
  logic [CW-1:0]    cnt_q;
  logic [7:0]       tx_q;
  logic             miso_q;
  logic             rise, fall, boundary, echo_ok;

  assign rise     = sck_s & ~sck_q;
  assign fall     = ~sck_s & sck_q;
  assign rx_nx    = {rx_q[WBITS-2:0], mosi_s};
  assign word_hit = rise && (cnt_q == LAST_BIT);
  assign mid_hit  = rise && (cnt_q == MID_BIT);
  assign boundary = rise && (cnt_q[2:0] == 3'd7);
  assign echo_ok  = (cnt_q == ECHO_BIT) && (rx_nx[15:8] == OP_PREFIX);

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_s;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      rx_q   <= '0;
      cnt_q  <= '0;
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      if (rise) begin
        rx_q  <= rx_nx;
        cnt_q <= cnt_q + 1'b1;
      end
      if (tx_load) begin
        tx_q <= tx_byte;
      end else if (boundary) begin
        tx_q <= echo_ok ? rx_nx[7:0] : 8'h00;
      end else if (fall) begin
        tx_q <= {tx_q[6:0], 1'b0};
      end
      if (fall) miso_q <= tx_q[7];
    end
  end

  assign miso = miso_q;

  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (clr)
    !fall |=> $stable(miso_q)) else $error("miso moved without falling sck"); // R2

  AST_BIT_COUNT: assert property (@(posedge clk) disable iff (clr)
    rise |=> (cnt_q == $past(cnt_q) + 1'b1)) else $error("bit count did not advance"); // R3

endmodule

// File: rtl/sprog_decode.sv
module sprog_decode
  import sprog_pkg::*;
#(
  parameter int PAW = 11,
  parameter int DAW = 8
) (
  input  logic                clk,
  input  logic                clr,
  input  logic [WORD_W-1:0]   rx,
  input  logic                word_hit,
  input  logic                mid_hit,
  input  logic [7:0]          mem_rdata,
  output logic                mem_req,
  output mem_cmd_e            mem_cmd,
  output logic [PAW-1:0]      mem_addr,
  output logic                mem_hi,
  output logic [7:0]          mem_wdata,
  output logic                tx_load,
  output logic [7:0]          tx_byte
);

  logic [7:0] w1, w2, w3, w4;
  logic [7:0] m1, m2, m3;
  assign {w1, w2, w3, w4} = rx;
  assign {m1, m2, m3}     = rx[23:0];

  function automatic logic [PAW-1:0] fit_prog(input logic [15:0] a);
    return a[PAW-1:0];
  endfunction

  function automatic logic [PAW-1:0] fit_data(input logic [15:0] a);
    return PAW'(a[DAW-1:0]);
  endfunction

  logic           en_q, rdw1_q, rdw2_q;
  logic           is_unlock, issue_c, read_c;
  mem_cmd_e       cmd_c;
  logic [PAW-1:0] addr_c;
  logic           hi_c;
  logic [7:0]     wd_c;

  assign is_unlock = (w1 == OP_PREFIX) && (w2 == OP_UNLOCK);

  always_comb begin
    issue_c = 1'b0;
    read_c  = 1'b0;
    cmd_c   = MC_ERASE;
    addr_c  = '0;
    hi_c    = 1'b0;
    wd_c    = 8'h00;
    if (en_q && word_hit && !is_unlock) begin
      if (w1 == OP_PREFIX && w2 == OP_ERASE) begin
        issue_c = 1'b1;
      end else if ((w1 & ~OP_HI_BIT) == OP_WR_PROG) begin
        issue_c = 1'b1;
        cmd_c   = MC_WR_PROG;
        addr_c  = fit_prog({w2, w3});
        hi_c    = w1[3];
        wd_c    = w4;
      end else if (w1 == OP_WR_DATA) begin
        issue_c = 1'b1;
        cmd_c   = MC_WR_DATA;
        addr_c  = fit_data({w2, w3});
        wd_c    = w4;
      end
    end else if (en_q && mid_hit) begin
      if ((m1 & ~OP_HI_BIT) == OP_RD_PROG) begin
        issue_c = 1'b1;
        read_c  = 1'b1;
        cmd_c   = MC_RD_PROG;
        addr_c  = fit_prog({m2, m3});
        hi_c    = m1[3];
      end else if (m1 == OP_RD_DATA) begin
        issue_c = 1'b1;
        read_c  = 1'b1;
        cmd_c   = MC_RD_DATA;
        addr_c  = fit_data({m2, m3});
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      en_q      <= 1'b0;
      mem_req   <= 1'b0;
      rdw1_q    <= 1'b0;
      rdw2_q    <= 1'b0;
      mem_cmd   <= MC_ERASE;
      mem_addr  <= '0;
      mem_hi    <= 1'b0;
      mem_wdata <= 8'h00;
    end else begin
      mem_req <= issue_c;
      rdw1_q  <= read_c;
      rdw2_q  <= rdw1_q;
      if (issue_c) begin
        mem_cmd   <= cmd_c;
        mem_addr  <= addr_c;
        mem_hi    <= hi_c;
        mem_wdata <= wd_c;
      end
      if (word_hit && is_unlock) en_q <= 1'b1;
    end
  end

  assign tx_load = rdw2_q;
  assign tx_byte = mem_rdata;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (clr)
    mem_req |=> !mem_req) else $error("request held two cycles"); // R11

  AST_REQ_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (clr)
    mem_req |-> en_q) else $error("request while locked"); // R6

  AST_UNLOCK_AT_WORD: assert property (@(posedge clk) disable iff (clr)
    $rose(en_q) |-> $past(word_hit)) else $error("unlock off boundary"); // R5

endmodule

// File: rtl/sprog_port.sv
module sprog_port
  import sprog_pkg::*;
#(
  parameter bit LARGE_MAP = 1'b0,
  localparam int PAW = LARGE_MAP ? 12 : 11,
  localparam int DAW = LARGE_MAP ? 9 : 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           prog_rst_n,
  input  logic           sck,
  input  logic           mosi,
  output logic           miso,
  output logic           mem_req,
  output logic [2:0]     mem_cmd,
  output logic [PAW-1:0] mem_addr,
  output logic           mem_hi,
  output logic [7:0]     mem_wdata,
  input  logic [7:0]     mem_rdata
);

  logic [2:0]        pins_s;
  logic              sel_n_s, sck_s, mosi_s, clr;
  logic [WORD_W-1:0] rx_nx;
  logic              word_hit, mid_hit, tx_load;
  logic [7:0]        tx_byte;
  mem_cmd_e          cmd_e;

  sprog_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({prog_rst_n, sck, mosi}),
    .q   (pins_s)
  );

  assign {sel_n_s, sck_s, mosi_s} = pins_s;
  assign clr = rst | sel_n_s;

  sprog_frame #(.WBITS(WORD_W)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .sck_s    (sck_s),
    .mosi_s   (mosi_s),
    .tx_load  (tx_load),
    .tx_byte  (tx_byte),
    .rx_nx    (rx_nx),
    .word_hit (word_hit),
    .mid_hit  (mid_hit),
    .miso     (miso)
  );

  sprog_decode #(.PAW(PAW), .DAW(DAW)) u_dec (
    .clk       (clk),
    .clr       (clr),
    .rx        (rx_nx),
    .word_hit  (word_hit),
    .mid_hit   (mid_hit),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_cmd   (cmd_e),
    .mem_addr  (mem_addr),
    .mem_hi    (mem_hi),
    .mem_wdata (mem_wdata),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte)
  );

  assign mem_cmd = cmd_e;

  AST_PORT_QUIET: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!miso && !mem_req)) else $error("port active while deselected"); // R1

endmodule

// File: tb/sprog_port_tb.sv
module sprog_port_tb_top;

  localparam int PAW = 11;

  logic           clk = 1'b0;
  logic           rst, prog_rst_n, sck, mosi;
  logic           miso, mem_req, mem_hi;
  logic [2:0]     mem_cmd;
  logic [PAW-1:0] mem_addr;
  logic [7:0]     mem_wdata;
  logic [7:0]     mem_rdata = 8'h00;

  always #2 clk = ~clk;

  sprog_port #(.LARGE_MAP(1'b0)) dut_i (
    .clk(clk), .rst(rst), .prog_rst_n(prog_rst_n), .sck(sck), .mosi(mosi),
    .miso(miso), .mem_req(mem_req), .mem_cmd(mem_cmd), .mem_addr(mem_addr),
    .mem_hi(mem_hi), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  int n_req = 0;
  int hold_bad = 0;
  bit done = 0;

  function automatic logic [7:0] mdl(input logic [2:0] c, input logic [PAW-1:0] a, input logic h);
    if (c == 3'd3) return a[7:0] ^ (h ? 8'h5A : 8'hA5);
    return a[7:0] ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_req) mem_rdata <= mdl(mem_cmd, mem_addr, mem_hi);

  typedef struct packed {
    logic [2:0]     cmd;
    logic [PAW-1:0] addr;
    logic           hi;
    logic [7:0]     wd;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input logic [2:0] c, input logic [PAW-1:0] a,
                      input logic h, input logic [7:0] d);
    exp_q.push_back('{cmd: c, addr: a, hi: h, wd: d});
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && mem_req) begin
      n_req++;
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R6 actual request cmd %0d addr %h expected none", mem_cmd, mem_addr);
      end else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {16'h0, mem_cmd, mem_hi, mem_wdata, 4'h0}, {16'h0, e.cmd, e.hi, e.wd, 4'h0});
        chk(t, 32'(mem_addr), 32'(e.addr));
      end
    end
  end

  task automatic bit_x(input logic b, output logic m);
    logic m2;
    @(negedge clk) mosi = b;
    repeat (3) @(negedge clk);
    m = miso;
    sck = 1'b1;
    repeat (4) @(negedge clk);
    m2 = miso;
    if (m2 !== m) hold_bad++;
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [31:0] w, output logic [31:0] got);
    for (int i = 31; i >= 0; i--) bit_x(w[i], got[i]);
    repeat (8) @(negedge clk);
  endtask

  task automatic port_reset();
    @(negedge clk) prog_rst_n = 1'b1;
    repeat (6) @(negedge clk);
    prog_rst_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] g;
    logic m;
    int base;
    rst = 1'b1; prog_rst_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 reset miso", 32'(miso), 0);
    chk("R1 reset req", 32'(mem_req), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 deselected miso", 32'(miso), 0);
    prog_rst_n = 1'b0;
    repeat (6) @(negedge clk);

    // locked: nothing issues (R6), echo still works (R4)
    xfer(32'h4800_1077, g);
    xfer(32'hC000_0511, g);
    xfer(32'h2000_0100, g);
    chk("R6 read locked miso", g, 32'h0);
    xfer(32'hAC80_0000, g);
    chk("R4 echo erase byte", g, 32'h0000_8000);
    chk("R6 no request locked", 32'(n_req), 0);

    // unlock (R5, R4)
    xfer(32'hAC53_9E41, g);
    chk("R4 unlock echo", g, 32'h0000_5300);
    push("R7 erase", 3'd0, '0, 1'b0, 8'h00);
    xfer(32'hAC80_1234, g);

    // program writes (R8, R12)
    push("R8 prog write", 3'd1, 11'h123, 1'b1, 8'h5A);
    xfer(32'h4801_235A, g);
    push("R12 prog mask", 3'd1, 11'h7FF, 1'b0, 8'hC3);
    xfer(32'h40FF_FFC3, g);

    // data writes (R9, R12)
    base = n_req;
    push("R9 data write", 3'd2, 11'h047, 1'b0, 8'h99);
    xfer(32'hC000_4799, g);
    chk("R9 single request", 32'(n_req - base), 1);
    push("R12 data mask", 3'd2, 11'h0FF, 1'b0, 8'h01);
    xfer(32'hC0FF_FF01, g);

    // reads (R10)
    push("R10 prog read", 3'd3, 11'h234, 1'b1, 8'h00);
    xfer(32'h2802_3400, g);
    chk("R10 prog read data", g, {24'h0, 8'h34 ^ 8'h5A});
    push("R10 data read", 3'd4, 11'h09B, 1'b0, 8'h00);
    xfer(32'hA001_9B00, g);
    chk("R10 data read data", g, {24'h0, 8'h9B ^ 8'h3C});

    // deselect clears unlock and partial framing (R1)
    port_reset();
    base = n_req;
    xfer(32'hAC80_0000, g);
    chk("R1 unlock cleared", 32'(n_req - base), 0);
    for (int i = 0; i < 12; i++) bit_x(1'b1, m);
    port_reset();
    xfer(32'hAC53_0000, g);
    chk("R1 framing restarted", g, 32'h0000_5300);
    push("R1 erase after restart", 3'd0, '0, 1'b0, 8'h00);
    xfer(32'hAC80_0000, g);

    // stray pulse misaligns framing (R3)
    bit_x(1'b0, m);
    base = n_req;
    xfer(32'hAC53_0000, g);
    chk("R3 no echo out of sync", 32'(g[15:8]), 0);
    xfer(32'hAC80_0000, g);
    chk("R3 no erase out of sync", 32'(n_req - base), 0);

    repeat (10) @(negedge clk);
    chk("R2 miso steady while sck high", 32'(hold_bad), 0);
    chk("R7 scoreboard drained", 32'(exp_q.size()), 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule